// File: doc/BRIEF.md
# In-order quad admission gatekeeper

The block decides, once per clock, what enters the first slot of a long, fixed-latency, strictly in-order shading pipeline. Each arriving pixel quad carries a per-pixel temporary-register count and a precision flag. The gatekeeper works out how many shared register-file entries the quad needs and admits it only if that many entries are free. An admitted quad holds its entries while it travels through every slot of the delay line, and gives them back in the cycle it leaves the last slot. The pipeline advances every cycle whatever happens. When no quad can be admitted, an empty slot (valid bit zero) goes in instead.

In reduced-precision mode two half-width values share one full-width register, so a quad needs half as many entries, rounded up. The number of quads in flight is therefore limited by register-file occupancy and not by the pipeline depth. Heavy temp usage causes empty slots, and the block counts them. Software-visible bookkeeping is limited to two saturating counters: quads launched and space-starved bubbles.

Top module: `quad_admit_gate`

## Requirements
- R1: While reset is high and in the cycle after it, `free_entries` equals POOL, both counters read zero and `out_valid` is low.
- R2: The entry cost of a quad is `in_temps` when `in_half` is 0, and ceil(`in_temps`/2) when `in_half` is 1.
- R3: `in_ready` is high exactly when the free entries plus the entries returned by a quad exiting this cycle are at least the cost of the presented quad. A quad is admitted on a clock edge where `in_valid` and `in_ready` are both high.
- R4: A quad admitted at edge k shows `out_valid` high with its own `in_tag` on `out_tag` between edges k+DEPTH-1 and k+DEPTH.
- R5: The pipeline advances on every edge and quads leave in admission order. An edge with no admission places an empty slot, which shows `out_valid` low DEPTH-1 edges later.
- R6: The entries of a quad are returned on the edge where it leaves the last slot, and `out_cost` shows their number while it is there. Entries returned on an edge may be granted to a new quad on that same edge. An empty slot returns nothing.
- R7: `free_entries` always equals POOL minus the summed cost of the quads in flight, and never exceeds POOL.
- R8: `launch_count` increases by one on each admission and holds at its maximum value 2^CNT_W-1.
- R9: `bubble_count` increases by one on each edge where `in_valid` is high and `in_ready` is low, and holds at 2^CNT_W-1. Edges with `in_valid` low do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A quad is presented |
| in_ready | output | 1 | The presented quad fits in the free register space |
| in_temps | input | 4 | Temporary registers per pixel |
| in_half | input | 1 | 1 = reduced precision, two values per register |
| in_tag | input | 8 | Quad identifier carried through the pipeline |
| out_valid | output | 1 | A real quad occupies the last slot |
| out_tag | output | 8 | Identifier of the quad in the last slot |
| out_cost | output | 4 | Entries that the quad in the last slot returns |
| free_entries | output | $clog2(POOL+1) | Unallocated register-file entries |
| launch_count | output | CNT_W | Saturating count of admitted quads |
| bubble_count | output | CNT_W | Saturating count of space-starved empty slots |

## Verification
`in_ready` is combinational, so it is sampled one time step after the inputs change, in the same cycle. The free count and both counters are due one edge after the stimulus and are compared at the following falling edge. A quad's tag and cost appear DEPTH-1 edges after its admission edge. The bench keeps a model of every slot, shifted once per rising edge, so each exit is compared in exactly that cycle. Same-cycle reuse of returned entries is checked under the R6 tag whenever the ready decision depends on a returning quad.

// File: rtl/qg_pkg.sv
package qg_pkg;
    localparam int TEMP_W = 4;
    localparam int TAG_W  = 8;

    typedef logic [TEMP_W-1:0] cost_t;

    typedef enum logic {
        PREC_FULL = 1'b0,
        PREC_HALF = 1'b1
    } prec_e;

    typedef struct packed {
        logic             valid;
        cost_t            cost;
        logic [TAG_W-1:0] tag;
    } slot_t;

    // Register-file entries needed by one quad
    function automatic cost_t entry_cost(input logic [TEMP_W-1:0] temps, input prec_e prec);
        logic [TEMP_W:0] rounded;
        rounded = {1'b0, temps} + {{TEMP_W{1'b0}}, 1'b1};
        if (prec == PREC_HALF) begin
            return rounded[TEMP_W:1];
        end
        return temps;
    endfunction
endpackage

// File: rtl/qg_delay_line.sv
module qg_delay_line
    import qg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t push,
    output slot_t tail
);
    slot_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= push;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign tail = stage_q[DEPTH-1];
endmodule

// File: rtl/qg_alloc.sv
module qg_alloc
    import qg_pkg::*;
#(
    parameter int POOL   = 512,
    parameter int POOL_W = $clog2(POOL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  cost_t             req_cost,
    input  logic              ret_valid,
    input  cost_t             ret_cost,
    output logic              grant_ok,
    output logic              accept,
    output logic [POOL_W-1:0] free_q
);
    localparam int SUM_W = POOL_W + 1;

    logic [SUM_W-1:0] avail;
    logic [SUM_W-1:0] ret_ext;
    logic [SUM_W-1:0] req_ext;
    logic [SUM_W-1:0] next_free;

    assign ret_ext  = ret_valid ? SUM_W'(ret_cost) : '0;
    assign req_ext  = SUM_W'(req_cost);
    assign avail    = SUM_W'(free_q) + ret_ext;
    assign grant_ok = (avail >= req_ext);
    assign accept   = req_valid && grant_ok;

    always_comb begin
        next_free = avail;
        if (accept) begin
            next_free = avail - req_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= POOL_W'(POOL);
        end else begin
            free_q <= next_free[POOL_W-1:0];
        end
    end
endmodule

// File: rtl/qg_sat_counter.sv
module qg_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/quad_admit_gate.sv
module quad_admit_gate
    import qg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int POOL  = 512,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [TEMP_W-1:0]           in_temps,
    input  logic                        in_half,
    input  logic [TAG_W-1:0]            in_tag,
    output logic                        out_valid,
    output logic [TAG_W-1:0]            out_tag,
    output logic [TEMP_W-1:0]           out_cost,
    output logic [$clog2(POOL+1)-1:0]   free_entries,
    output logic [CNT_W-1:0]            launch_count,
    output logic [CNT_W-1:0]            bubble_count
);
    localparam int POOL_W = $clog2(POOL + 1);

    cost_t head_cost;
    logic  grant_ok;
    logic  accept;
    slot_t push_slot;
    slot_t tail_slot;

    assign head_cost = entry_cost(in_temps, prec_e'(in_half));

    qg_alloc #(
        .POOL   (POOL),
        .POOL_W (POOL_W)
    ) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .req_valid (in_valid),
        .req_cost  (head_cost),
        .ret_valid (tail_slot.valid),
        .ret_cost  (tail_slot.cost),
        .grant_ok  (grant_ok),
        .accept    (accept),
        .free_q    (free_entries)
    );

    always_comb begin
        push_slot = '0;
        if (accept) begin
            push_slot.valid = 1'b1;
            push_slot.cost  = head_cost;
            push_slot.tag   = in_tag;
        end
    end

    qg_delay_line #(
        .DEPTH (DEPTH)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .push (push_slot),
        .tail (tail_slot)
    );

    qg_sat_counter #(.W(CNT_W)) u_launch_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (accept),
        .count (launch_count)
    );

    qg_sat_counter #(.W(CNT_W)) u_bubble_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (in_valid && !grant_ok),
        .count (bubble_count)
    );

    assign in_ready  = grant_ok;
    assign out_valid = tail_slot.valid;
    assign out_tag   = tail_slot.tag;
    assign out_cost  = tail_slot.cost;
endmodule

// File: rtl/qg_checker.sv
module qg_checker #(
    parameter int POOL   = 512,
    parameter int CNT_W  = 16,
    parameter int POOL_W = $clog2(POOL + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [3:0]        out_cost,
    input logic [POOL_W-1:0] free_entries,
    input logic [CNT_W-1:0]  launch_count,
    input logic [CNT_W-1:0]  bubble_count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (free_entries == POOL_W'(POOL) && launch_count == '0 && bubble_count == '0 && !out_valid)); // R1

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_entries <= POOL_W'(POOL)); // R7

    AST_FREE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=>
        (POOL_W+1)'(free_entries) == (POOL_W+1)'($past(free_entries)) + (POOL_W+1)'($past(out_cost))); // R6

    AST_IDLE_FREE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> $stable(free_entries)); // R6

    AST_LAUNCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && launch_count != CMAX) |=> launch_count == $past(launch_count) + 1'b1); // R8

    AST_LAUNCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(launch_count)); // R8

    AST_BUBBLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && bubble_count != CMAX) |=> bubble_count == $past(bubble_count) + 1'b1); // R9

    AST_IDLE_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(bubble_count)); // R9
endmodule

bind quad_admit_gate qg_checker #(
    .POOL  (POOL),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_cost     (out_cost),
    .free_entries (free_entries),
    .launch_count (launch_count),
    .bubble_count (bubble_count)
);

// File: tb/quad_admit_gate_tb.sv
`timescale 1ns/1ps
module quad_admit_gate_tb;
    localparam int DEPTH  = 8;
    localparam int POOL   = 24;
    localparam int CNT_W  = 6;
    localparam int POOL_W = $clog2(POOL + 1);
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [3:0]        in_temps = '0;
    logic              in_half = 1'b0;
    logic [7:0]        in_tag = '0;
    logic              out_valid;
    logic [7:0]        out_tag;
    logic [3:0]        out_cost;
    logic [POOL_W-1:0] free_entries;
    logic [CNT_W-1:0]  launch_count;
    logic [CNT_W-1:0]  bubble_count;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements
    bit m_v    [DEPTH];
    int m_cost [DEPTH];
    int m_tag  [DEPTH];
    int m_free;
    int m_launch;
    int m_bub;
    int next_tag = 0;

    always #5 clk = ~clk;

    quad_admit_gate #(
        .DEPTH (DEPTH),
        .POOL  (POOL),
        .CNT_W (CNT_W)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_temps     (in_temps),
        .in_half      (in_half),
        .in_tag       (in_tag),
        .out_valid    (out_valid),
        .out_tag      (out_tag),
        .out_cost     (out_cost),
        .free_entries (free_entries),
        .launch_count (launch_count),
        .bubble_count (bubble_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cost_of(input int t, input bit h);
        return h ? (t + 1) / 2 : t;
    endfunction

    task automatic step(input bit v, input int t, input bit h);
        int  c;
        int  ret;
        int  avail;
        bit  rdy;
        bit  acc;
        int  g;
        g = next_tag & 8'hFF;
        in_valid = v;
        in_temps = t[3:0];
        in_half  = h;
        in_tag   = g[7:0];
        #1;
        c     = cost_of(t, h);
        ret   = m_v[DEPTH-1] ? m_cost[DEPTH-1] : 0;
        avail = m_free + ret;
        rdy   = (avail >= c);
        if (ret > 0 && (m_free < c))
            check(in_ready == rdy, "R6", int'(in_ready), int'(rdy)); // reuse of returning entries
        else
            check(in_ready == rdy, "R3", int'(in_ready), int'(rdy));
        acc = v && rdy;
        @(posedge clk);
        for (int i = DEPTH - 1; i > 0; i--) begin
            m_v[i]    = m_v[i-1];
            m_cost[i] = m_cost[i-1];
            m_tag[i]  = m_tag[i-1];
        end
        m_v[0]    = acc;
        m_cost[0] = acc ? c : 0;
        m_tag[0]  = acc ? g : 0;
        m_free    = avail - (acc ? c : 0);
        if (acc) next_tag++;
        if (acc && m_launch != CMAX) m_launch++;
        if (v && !rdy && m_bub != CMAX) m_bub++;
        @(negedge clk);
        check(out_valid == m_v[DEPTH-1], "R5", int'(out_valid), int'(m_v[DEPTH-1]));
        if (m_v[DEPTH-1]) begin
            check(int'(out_tag) == m_tag[DEPTH-1], "R4", int'(out_tag), m_tag[DEPTH-1]);
            check(int'(out_cost) == m_cost[DEPTH-1], "R6", int'(out_cost), m_cost[DEPTH-1]);
        end
        check(int'(free_entries) == m_free, "R7", int'(free_entries), m_free);
        check(int'(launch_count) == m_launch, "R8", int'(launch_count), m_launch);
        check(int'(bubble_count) == m_bub, "R9", int'(bubble_count), m_bub);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_cost[i] = 0; m_tag[i] = 0;
        end
        m_free = POOL; m_launch = 0; m_bub = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state in the first cycle after reset
        check(int'(free_entries) == POOL, "R1", int'(free_entries), POOL);
        check(launch_count == '0, "R1", int'(launch_count), 0);
        check(bubble_count == '0, "R1", int'(bubble_count), 0);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R2: half precision, 5 temps -> 3 entries
        step(1'b1, 5, 1'b1);
        check(int'(free_entries) == POOL - 3, "R2", int'(free_entries), POOL - 3);
        // R2: full precision, 5 temps -> 5 entries
        step(1'b1, 5, 1'b0);
        check(int'(free_entries) == POOL - 8, "R2", int'(free_entries), POOL - 8);
        // R2: half precision, 0 temps -> 0 entries, always admitted
        step(1'b1, 0, 1'b1);
        check(int'(free_entries) == POOL - 8, "R2", int'(free_entries), POOL - 8);

        // Drain, then saturate the pool with 4-entry quads: R3, R5 bubbles
        repeat (DEPTH + 2) step(1'b0, 0, 1'b0);
        repeat (3 * DEPTH) step(1'b1, 4, 1'b0);
        // Cost 8 quads back to back: R6 same-cycle reuse as each one exits
        repeat (3 * DEPTH) step(1'b1, 8, 1'b0);
        // Largest cost, half and full
        repeat (2 * DEPTH) step(1'b1, 15, 1'b0);
        repeat (2 * DEPTH) step(1'b1, 15, 1'b1);
        // Idle gap: R9 bubble counter must hold
        repeat (DEPTH + 2) step(1'b0, 15, 1'b0);

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int t;
            bit v;
            bit h;
            v = ($urandom_range(0, 9) < 7);
            h = $urandom_range(0, 1) == 1;
            t = ($urandom_range(0, 3) == 0) ? $urandom_range(10, 15) : $urandom_range(0, 6);
            step(v, t, h);
        end
        repeat (DEPTH + 2) step(1'b0, 0, 1'b0);
        check(int'(free_entries) == POOL, "R7", int'(free_entries), POOL);
        check(int'(launch_count) == CMAX, "R8", int'(launch_count), CMAX);
        check(int'(bubble_count) == CMAX, "R9", int'(bubble_count), CMAX);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule